// File: doc/BRIEF.md
# I2C Bus Timeout and Recovery Sequencer

This block supervises a two-wire bus on behalf of a master controller. While a transfer is active it measures how long the clock line stays low. When that time reaches the counter's terminal value, or when the controller reports lost arbitration, the block takes over and runs a fixed recovery routine. The controller's own state is discarded, the block waits for SCL to be released, and it frees a target that is stuck driving SDA low by sending it single clock pulses. It then either asks the controller for a STOP or resets the controller back into idle slave-receive operation.

The sequencer reports each recovery as exactly one result pulse: done, or error with a code. The error codes separate a clock line held low by another device from a data line that stays low after the maximum number of pulses. Pulse high and low times are parameters that are sized for 400 kbit/s at the system clock rate. Only one recovery runs at a time.

Top module: `i2c_bus_recovery`

## Requirements
- R1: While idle, a fault is raised only after `xfer_active` is high and SCL is low on 2^TO_WIDTH-1 consecutive clock edges. Any cycle with SCL high or `xfer_active` low restarts the count.
- R2: A fault from either source (`arb_lost` pulse or the R1 timeout) puts the block into recovery. The first recovery cycle has `xfer_failed` and `ctl_reset` high for exactly one cycle, with SCL not driven.
- R3: While `in_recovery` is high, further `arb_lost` pulses and timeouts have no effect. `xfer_failed` rises only once per recovery.
- R4: After the reset cycle the block waits for SCL high. If SCL stays low for 2^TO_WIDTH-1 edges, recovery ends in error with `error_code` = 2'b01.
- R5: With SCL high and SDA low, the block sends one pulse. It drives `scl_drive_low` for T_LOW cycles, then releases SCL and counts T_HIGH cycles in which SCL reads high, and only then samples SDA again.
- R6: If SDA is still low after MAX_PULSES pulses, recovery ends in error with `error_code` = 2'b10. No pulse beyond MAX_PULSES is sent.
- R7: When SDA reads high and `bus_busy` is high, `stop_req` is high for one cycle, followed by `rec_done`.
- R8: When SDA reads high and `bus_busy` is low, `ctl_reset` is high for one cycle, followed by `rec_done`.
- R9: If SCL is held low during the released half of a pulse for 2^TO_WIDTH-1 edges, recovery ends in error with `error_code` = 2'b01.
- R10: During and right after reset, every output is low and `error_code` is 2'b00.
- R11: `rec_done` and `rec_error` are never high together. Each lasts one cycle and is followed by idle. `error_code` holds its value until the next fault, which clears it to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised level of the SCL line |
| sda_in | input | 1 | Synchronised level of the SDA line |
| bus_busy | input | 1 | Bus held busy (START seen, no STOP yet) |
| xfer_active | input | 1 | Controller has a transfer in progress |
| arb_lost | input | 1 | One-cycle arbitration-lost pulse from the controller |
| scl_drive_low | output | 1 | Pull SCL low (recovery pulse low phase) |
| ctl_reset | output | 1 | Internal reset pulse to the controller |
| xfer_failed | output | 1 | One-cycle pulse: current transfer failed |
| stop_req | output | 1 | One-cycle request for the controller to issue STOP |
| in_recovery | output | 1 | Recovery sequence in progress |
| rec_done | output | 1 | One-cycle pulse: recovery finished cleanly |
| rec_error | output | 1 | One-cycle pulse: recovery ended in error |
| error_code | output | 2 | 00 none, 01 SCL stuck low, 10 SDA stuck low |

## Verification
The bench models SCL as a wired-AND line and models a target that keeps SDA low for a chosen number of SCL rising edges. This lets it hit zero, a few, and more than nine required pulses. If the pulse limit were off by one, the error would come one pulse early or late, and the per-cycle comparison against the behavioural model catches that. A timeout counter that missed a break in the low time would raise a false fault on the gapped stimulus. A sequencer that accepted faults during recovery would show a second `xfer_failed` while `arb_lost` is pulsed mid-sequence. A clock held low during the released half of a pulse has to give the SCL-stuck code and not the SDA-stuck one.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;

  typedef enum logic [3:0] {
    RS_IDLE,   // watching the bus
    RS_IRST,   // controller reset, lines released
    RS_WAIT,   // waiting for SCL release
    RS_CHECK,  // sample SDA, choose next step
    RS_LOW,    // pulse: SCL driven low
    RS_HIGH,   // pulse: SCL released
    RS_STOP,   // ask controller for STOP
    RS_RSTI,   // reset controller into idle
    RS_DONE,   // clean result
    RS_ERR     // failed result
  } rec_state_e;

  localparam logic [1:0] EC_NONE = 2'b00;
  localparam logic [1:0] EC_SCL  = 2'b01;
  localparam logic [1:0] EC_SDA  = 2'b10;

endpackage

// File: rtl/i2c_rec_timeout.sv
module i2c_rec_timeout #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic expired
);

  localparam logic [WIDTH-1:0] LIMIT = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt;

  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] c, input logic en);
    if (!en)          return '0;
    else if (c == LIMIT) return c;
    else              return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= step(cnt, count_en);
  end

  assign expired = (cnt == LIMIT);

  // R1: a cycle without the counting condition restarts the count
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> !expired);

  // R1: expiry holds while the condition persists
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && count_en) |=> expired);

endmodule

// File: rtl/i2c_rec_seq.sv
module i2c_rec_seq
  import i2c_rec_pkg::*;
#(
  parameter int T_LOW      = 130,
  parameter int T_HIGH     = 60,
  parameter int MAX_PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       bus_busy,
  input  logic       xfer_active,
  input  logic       arb_lost,
  input  logic       to_expired,
  output logic       to_en,
  output logic       scl_drive_low,
  output logic       ctl_reset,
  output logic       xfer_failed,
  output logic       stop_req,
  output logic       in_recovery,
  output logic       rec_done,
  output logic       rec_error,
  output logic [1:0] error_code
);

  localparam int MAXT = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int PW   = $clog2(MAX_PULSES + 1);

  rec_state_e    state, state_d;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pulses;
  logic          low_end, high_end, pulse_end, limit_hit;

  function automatic logic [TW-1:0] timer_next(input logic [TW-1:0] t,
                                               input logic moved, input logic adv);
    if (moved)    return '0;
    else if (adv) return t + 1'b1;
    else          return t;
  endfunction

  assign low_end   = (tcnt == TW'(T_LOW - 1));
  assign high_end  = scl_in && (tcnt == TW'(T_HIGH - 1));
  assign limit_hit = (pulses == PW'(MAX_PULSES));
  assign pulse_end = (state == RS_HIGH) && (state_d == RS_CHECK);

  always_comb begin
    state_d = state;
    to_en   = 1'b0;
    case (state)
      RS_IDLE: begin
        to_en = xfer_active && !scl_in;
        if (arb_lost || to_expired) state_d = RS_IRST;
      end
      RS_IRST: state_d = RS_WAIT;
      RS_WAIT: begin
        to_en = !scl_in;
        if (to_expired)  state_d = RS_ERR;
        else if (scl_in) state_d = RS_CHECK;
      end
      RS_CHECK: begin
        if (sda_in)         state_d = bus_busy ? RS_STOP : RS_RSTI;
        else if (limit_hit) state_d = RS_ERR;
        else                state_d = RS_LOW;
      end
      RS_LOW: if (low_end) state_d = RS_HIGH;
      RS_HIGH: begin
        to_en = !scl_in;
        if (to_expired)    state_d = RS_ERR;
        else if (high_end) state_d = RS_CHECK;
      end
      RS_STOP, RS_RSTI: state_d = RS_DONE;
      default:          state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RS_IDLE;
      tcnt       <= '0;
      pulses     <= '0;
      error_code <= EC_NONE;
    end else begin
      state <= state_d;
      tcnt  <= timer_next(tcnt, state_d != state,
                          (state == RS_LOW) || (state == RS_HIGH && scl_in));
      if (state == RS_IRST)  pulses <= '0;
      else if (pulse_end)    pulses <= pulses + 1'b1;
      if (state == RS_IRST)  error_code <= EC_NONE;
      else if (state_d == RS_ERR && state != RS_ERR)
        error_code <= (state == RS_CHECK) ? EC_SDA : EC_SCL;
    end
  end

  assign scl_drive_low = (state == RS_LOW);
  assign ctl_reset     = (state == RS_IRST) || (state == RS_RSTI);
  assign xfer_failed   = (state == RS_IRST);
  assign stop_req      = (state == RS_STOP);
  assign in_recovery   = (state != RS_IDLE);
  assign rec_done      = (state == RS_DONE);
  assign rec_error     = (state == RS_ERR);

  // R1 / R2: an expired timer while idle starts a recovery
  p_timeout_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (to_expired && !in_recovery) |=> xfer_failed);

  // R3: a failure pulse only marks entry from idle
  p_single_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_failed |-> !$past(in_recovery));

  // R4: an error always carries a cause
  p_err_has_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_error |-> (error_code != EC_NONE));

  // R5: the low half never ends before T_LOW cycles
  p_low_then_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && !low_end) |=> scl_drive_low);

  // R6: pulse count stays within the cap
  p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PW'(MAX_PULSES));

  // R6: SDA error only after the full pulse budget
  p_sda_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_error && error_code == EC_SDA) |-> limit_hit);

  // R7: STOP request is followed by the done pulse
  p_stop_then_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> rec_done);

  // R11: results exclusive and single-cycle
  p_result_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_done && rec_error));
  p_result_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done || rec_error) |=> !in_recovery);

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
  parameter int TO_WIDTH   = 16,
  parameter int T_LOW      = 130,
  parameter int T_HIGH     = 60,
  parameter int MAX_PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       bus_busy,
  input  logic       xfer_active,
  input  logic       arb_lost,
  output logic       scl_drive_low,
  output logic       ctl_reset,
  output logic       xfer_failed,
  output logic       stop_req,
  output logic       in_recovery,
  output logic       rec_done,
  output logic       rec_error,
  output logic [1:0] error_code
);

  logic to_en;
  logic to_expired;

  i2c_rec_timeout #(.WIDTH(TO_WIDTH)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (to_en),
    .expired  (to_expired)
  );

  i2c_rec_seq #(
    .T_LOW      (T_LOW),
    .T_HIGH     (T_HIGH),
    .MAX_PULSES (MAX_PULSES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .bus_busy      (bus_busy),
    .xfer_active   (xfer_active),
    .arb_lost      (arb_lost),
    .to_expired    (to_expired),
    .to_en         (to_en),
    .scl_drive_low (scl_drive_low),
    .ctl_reset     (ctl_reset),
    .xfer_failed   (xfer_failed),
    .stop_req      (stop_req),
    .in_recovery   (in_recovery),
    .rec_done      (rec_done),
    .rec_error     (rec_error),
    .error_code    (error_code)
  );

endmodule

// File: tb/i2c_bus_recovery_test.sv
module i2c_bus_recovery_test;

  localparam int TOW = 5;
  localparam int TO_MAX = (1 << TOW) - 1;
  localparam int TL = 3;
  localparam int TH = 2;
  localparam int NP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_busy = 1'b0, xfer_active = 1'b0, arb_lost = 1'b0;
  logic tb_scl_hold = 1'b0;
  int   sda_left = 0;

  logic scl_drive_low, ctl_reset, xfer_failed, stop_req, in_recovery, rec_done, rec_error;
  logic [1:0] error_code;
  logic scl_line, sda_line;

  assign scl_line = !scl_drive_low && !tb_scl_hold;
  assign sda_line = (sda_left == 0);

  always #5 clk = ~clk;

  i2c_bus_recovery #(.TO_WIDTH(TOW), .T_LOW(TL), .T_HIGH(TH), .MAX_PULSES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .bus_busy(bus_busy), .xfer_active(xfer_active), .arb_lost(arb_lost),
    .scl_drive_low(scl_drive_low), .ctl_reset(ctl_reset), .xfer_failed(xfer_failed),
    .stop_req(stop_req), .in_recovery(in_recovery), .rec_done(rec_done),
    .rec_error(rec_error), .error_code(error_code)
  );

  // target that keeps SDA low for a number of SCL rising edges
  always @(posedge scl_line) if (sda_left > 0) sda_left = sda_left - 1;

  int errors = 0, checks = 0, cyc = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // behavioural reference: phase numbers with integer timers
  int m_ph = 0, m_to = 0, m_t = 0, m_np = 0, m_code = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_to = 0; m_t = 0; m_np = 0; m_code = 0;
    end else begin
      int nx;
      bit en, expd;
      expd = (m_to == TO_MAX);
      nx = m_ph;
      en = 0;
      case (m_ph)
        0: begin en = xfer_active && !scl_line; if (arb_lost || expd) nx = 1; end
        1: begin nx = 2; m_np = 0; m_code = 0; end
        2: begin en = !scl_line;
                 if (expd) begin nx = 9; m_code = 1; end else if (scl_line) nx = 3; end
        3: begin if (sda_line) nx = bus_busy ? 6 : 7;
                 else if (m_np == NP) begin nx = 9; m_code = 2; end else nx = 4; end
        4: begin m_t++; if (m_t == TL) nx = 5; end
        5: begin en = !scl_line;
                 if (expd) begin nx = 9; m_code = 1; end
                 else if (scl_line) begin m_t++; if (m_t == TH) begin nx = 3; m_np++; end end end
        6, 7: nx = 8;
        default: nx = 0;
      endcase
      if (nx != m_ph) m_t = 0;
      m_to = en ? ((m_to < TO_MAX) ? m_to + 1 : m_to) : 0;
      m_ph = nx;
    end
  end

  // per-cycle comparison and event monitor
  int n_pulse = 0, n_fail = 0, n_stop = 0, n_rst = 0, n_done = 0, n_err = 0;
  logic prev_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5", "scl_drive_low", scl_drive_low, m_ph == 4);
      chk("R8", "ctl_reset", ctl_reset, (m_ph == 1) || (m_ph == 7));
      chk("R2", "xfer_failed", xfer_failed, m_ph == 1);
      chk("R7", "stop_req", stop_req, m_ph == 6);
      chk("R3", "in_recovery", in_recovery, m_ph != 0);
      chk("R11", "rec_done", rec_done, m_ph == 8);
      chk("R11", "rec_error", rec_error, m_ph == 9);
      chk("R4", "error_code", error_code, m_code);
      if (scl_drive_low && !prev_low) n_pulse++;
      if (xfer_failed) n_fail++;
      if (stop_req) n_stop++;
      if (ctl_reset) n_rst++;
      if (rec_done) n_done++;
      if (rec_error) n_err++;
      prev_low = scl_drive_low;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic clear_counts();
    n_pulse = 0; n_fail = 0; n_stop = 0; n_rst = 0; n_done = 0; n_err = 0;
  endtask

  task automatic pulse_arb();
    @(negedge clk) arb_lost = 1'b1;
    @(negedge clk) arb_lost = 1'b0;
  endtask

  task automatic wait_result();
    int n = 0;
    while (!(rec_done || rec_error) && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "outputs in reset",
        {scl_drive_low, ctl_reset, xfer_failed, stop_req, in_recovery, rec_done, rec_error}, 0);
    chk("R10", "error_code in reset", error_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "outputs after reset", {in_recovery, scl_drive_low, ctl_reset}, 0);

    // R2 + R7: arbitration loss, lines free, bus busy
    clear_counts(); bus_busy = 1'b1;
    pulse_arb(); wait_result();
    chk("R2", "failure pulses", n_fail, 1);
    chk("R7", "stop requests", n_stop, 1);
    chk("R7", "done pulses", n_done, 1);
    chk("R5", "no pulses with SDA free", n_pulse, 0);

    // R1: gapped low time and low without a transfer raise nothing
    clear_counts(); bus_busy = 1'b0;
    tb_scl_hold = 1'b1; repeat (TO_MAX + 10) @(negedge clk);
    xfer_active = 1'b1; repeat (TO_MAX - 5) @(negedge clk);
    tb_scl_hold = 1'b0; @(negedge clk);
    tb_scl_hold = 1'b1; repeat (TO_MAX - 5) @(negedge clk);
    chk("R1", "no fault before full low time", n_fail, 0);
    // R1 + R8: full low time trips, bus idle -> controller reset
    while (!xfer_failed) @(negedge clk);
    tb_scl_hold = 1'b0; xfer_active = 1'b0;
    wait_result();
    chk("R1", "timeout fault", n_fail, 1);
    chk("R8", "reset pulses (entry + idle)", n_rst, 2);
    chk("R8", "done pulses", n_done, 1);

    // R5 + R3: three pulses needed, arb_lost pulsed during recovery
    clear_counts(); bus_busy = 1'b1; sda_left = 3;
    pulse_arb();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) arb_lost = (i % 3 == 0);
    end
    arb_lost = 1'b0;
    wait_result();
    chk("R5", "pulses to free SDA", n_pulse, 3);
    chk("R3", "single failure despite extra faults", n_fail, 1);
    chk("R7", "stop after freeing", n_stop, 1);

    // R6: SDA never released
    clear_counts(); sda_left = 50;
    pulse_arb(); wait_result();
    chk("R6", "pulse budget", n_pulse, NP);
    chk("R6", "error result", n_err, 1);
    chk("R6", "error code SDA", error_code, 2);
    chk("R11", "code held after result", error_code, 2);

    // R4: SCL held through the release wait
    clear_counts(); sda_left = 0; tb_scl_hold = 1'b1;
    pulse_arb(); wait_result();
    tb_scl_hold = 1'b0;
    chk("R4", "error result", n_err, 1);
    chk("R4", "error code SCL", error_code, 1);
    chk("R4", "no pulses", n_pulse, 0);

    // R9: SCL held during the released half of the first pulse
    clear_counts(); sda_left = 20;
    pulse_arb();
    while (!scl_drive_low) @(negedge clk);
    while (scl_drive_low) @(negedge clk);
    tb_scl_hold = 1'b1;
    wait_result();
    tb_scl_hold = 1'b0;
    chk("R9", "error result", n_err, 1);
    chk("R9", "error code SCL", error_code, 1);
    chk("R9", "single pulse", n_pulse, 1);
    sda_left = 0;

    // R11: next fault clears the code
    clear_counts(); bus_busy = 1'b0;
    pulse_arb(); @(negedge clk);
    chk("R11", "code cleared by new fault", error_code, 0);
    wait_result();
    chk("R11", "done only", n_done * 10 + n_err, 10);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule